// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address that a PCI-style bus master presents for a DMA transfer into a system address. It has four programmable windows. Each window holds a base value, a mask and a translated base. A bus address that falls inside an enabled window keeps its low offset bits, and the translated base of that window supplies the upper bits. The windows are checked in a fixed priority order. A window programmed for scatter-gather mapping is not translated. A match on such a window raises an error flag instead.

Software programs the windows through a 64-bit register port. Registers are spaced 64 bytes apart above a base address that is set by a parameter. Only full 64-bit accesses are accepted. Two housekeeping registers accept writes, which have no effect, and read as zero. Every other offset, including the error, latency, reserved and performance-monitor slots, returns an error response. The translation path is purely combinational. The bus-side logic sees the result in the same cycle that it presents the address.

Top module: `pci_dma_xlate`

## Requirements
- R1: The register index is (reg_addr - BASE_ADDR) >> 6. Index i (0..3) holds the base register of window i, index 4+i holds its mask register and index 8+i holds its translated base. A 64-bit write to any of these indices is stored from the next clock edge, and a 64-bit read returns the stored value.
- R2: reg_size encodes the access width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. An access with reg_size other than 3 raises reg_err, returns zero on reg_rdata and changes no register.
- R3: A window matches when bus_addr equals its base register on every bit of the field [30:20] whose mask-register bit is zero. Bits outside [30:20] take no part in the compare.
- R4: Bit 0 of a base register enables its window. A window whose enable bit is clear is skipped, and the search continues with the next window.
- R5: On a direct-mapped hit, the offset mask is mask[30:20] combined with bits [19:0] all set. xl_addr is the translated base with the offset-mask bits cleared, ORed with the bus_addr bits under the offset mask.
- R6: Windows are examined from index 0 up to index 3. The first enabled, matching window alone decides the result.
- R7: When the deciding window has bit 1 of its base register set (scatter-gather), xl_err is 1, xl_hit is 0 and xl_addr is 0.
- R8: When no enabled window matches, xl_hit and xl_err are 0 and xl_addr is 0.
- R9: Index 12 (clock control) and index 13 (translation-cache invalidate) read as zero without error. Writes to them are accepted without error and change nothing.
- R10: Any other index, including 14 to 20 (error, error mask, error set, latency, reserved, monitor control, monitor count), and any address below BASE_ADDR or at 32 or more indices above it, raises reg_err, reads zero and changes no register.
- R11: Synchronous active-high reset clears all twelve window registers to zero, so that no window is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RA_W | Register byte address |
| reg_size | input | 2 | Access width code |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational |
| reg_err | output | 1 | Access error, combinational |
| bus_addr | input | 64 | Bus address to translate |
| xl_hit | output | 1 | Direct-mapped translation valid |
| xl_err | output | 1 | Scatter-gather window matched |
| xl_addr | output | 64 | Translated system address |

## Verification
A register decoded into the wrong slot, or a write that is wrongly accepted, stays hidden in the register file until software reads that slot or until a bus address lands in the affected window. The bench therefore reads back every window register it touches, and after each rejected or ignored write it reads the slot that could have changed. A fault in the compare, the splice or the priority chain shows on xl_hit, xl_err or xl_addr in the same cycle as the bus address. The bench chooses addresses that overlap several windows, sit just outside a window's field, or differ only in bits outside [30:20].

// File: rtl/pci_dma_xlate_pkg.sv
package pci_dma_xlate_pkg;

    localparam int DW         = 64;
    localparam int STRIDE_LOG = 6;
    localparam int IDX_W      = 5;
    localparam logic [1:0] SIZE_64 = 2'd3;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] mask;
        logic [DW-1:0] tbase;
    } win_cfg_t;

    typedef struct packed {
        logic          hit;
        logic          sg;
        logic [DW-1:0] addr;
    } win_res_t;

    typedef enum logic [2:0] {
        RK_BASE,
        RK_MASK,
        RK_TBASE,
        RK_ZERO,
        RK_BAD
    } reg_kind_e;

    function automatic logic [DW-1:0] field_bits(input int lsb, input int nbits);
        logic [DW-1:0] m;
        m = '0;
        for (int b = 0; b < DW; b++) begin
            if (b >= lsb && b < lsb + nbits) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] low_bits(input int nbits);
        logic [DW-1:0] m;
        m = '0;
        for (int b = 0; b < DW; b++) begin
            if (b < nbits) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pdx_regbank.sv
module pdx_regbank
    import pci_dma_xlate_pkg::*;
#(
    parameter int              NWIN      = 4,
    parameter int              RA_W      = 32,
    parameter logic [RA_W-1:0] BASE_ADDR = 32'h0001_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_req,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [1:0]           reg_size,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 reg_err,
    output win_cfg_t [NWIN-1:0]  cfg
);

    localparam int SLOT_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int CLK_IDX = 3 * NWIN;
    localparam int INV_IDX = 3 * NWIN + 1;

    win_cfg_t [NWIN-1:0] cfg_q;
    logic [RA_W-1:0]     diff;
    logic [IDX_W-1:0]    idx;
    logic                in_span;
    logic                unused_low;
    reg_kind_e           kind;
    logic [SLOT_W-1:0]   slot;
    logic [DW-1:0]       sel;
    logic                size_ok;

    assign diff       = reg_addr - BASE_ADDR;
    assign idx        = diff[STRIDE_LOG +: IDX_W];
    assign in_span    = (diff >> (STRIDE_LOG + IDX_W)) == '0;
    assign unused_low = ^diff[STRIDE_LOG-1:0];
    assign size_ok    = (reg_size == SIZE_64);

    always_comb begin
        kind = RK_BAD;
        slot = '0;
        if (in_span) begin
            if (int'(idx) < NWIN) begin
                kind = RK_BASE;
                slot = SLOT_W'(int'(idx));
            end else if (int'(idx) < 2 * NWIN) begin
                kind = RK_MASK;
                slot = SLOT_W'(int'(idx) - NWIN);
            end else if (int'(idx) < 3 * NWIN) begin
                kind = RK_TBASE;
                slot = SLOT_W'(int'(idx) - 2 * NWIN);
            end else if (int'(idx) == CLK_IDX || int'(idx) == INV_IDX) begin
                kind = RK_ZERO;
            end
        end
    end

    always_comb begin
        case (kind)
            RK_BASE:  sel = cfg_q[slot].base;
            RK_MASK:  sel = cfg_q[slot].mask;
            RK_TBASE: sel = cfg_q[slot].tbase;
            default:  sel = '0;
        endcase
    end

    assign reg_err   = reg_req && (!size_ok || kind == RK_BAD);
    assign reg_rdata = (reg_req && !reg_err) ? sel : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reg_req && reg_wr && !reg_err) begin
            case (kind)
                RK_BASE:  cfg_q[slot].base  <= reg_wdata;
                RK_MASK:  cfg_q[slot].mask  <= reg_wdata;
                RK_TBASE: cfg_q[slot].tbase <= reg_wdata;
                default:  ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pdx_window.sv
module pdx_window
    import pci_dma_xlate_pkg::*;
#(
    parameter int FIELD_LSB  = 20,
    parameter int FIELD_BITS = 11
) (
    input  win_cfg_t      cfg,
    input  logic [DW-1:0] bus_addr,
    output win_res_t      res
);

    localparam logic [DW-1:0] FIELD = field_bits(FIELD_LSB, FIELD_BITS);
    localparam logic [DW-1:0] LOW   = low_bits(FIELD_LSB);

    logic [DW-1:0] cmp_sel;
    logic [DW-1:0] off_sel;
    logic          same;

    assign cmp_sel  = ~cfg.mask & FIELD;
    assign off_sel  = (cfg.mask & FIELD) | LOW;
    assign same     = ((bus_addr ^ cfg.base) & cmp_sel) == '0;

    assign res.hit  = same && cfg.base[0];
    assign res.sg   = cfg.base[1];
    assign res.addr = (cfg.tbase & ~off_sel) | (bus_addr & off_sel);

endmodule

// File: rtl/pdx_pick.sv
module pdx_pick
    import pci_dma_xlate_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_res_t [NWIN-1:0] res,
    output logic                hit,
    output logic                err,
    output logic [DW-1:0]       addr
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        hit   = 1'b0;
        err   = 1'b0;
        addr  = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (!taken && res[i].hit) begin
                taken = 1'b1;
                hit   = !res[i].sg;
                err   = res[i].sg;
                addr  = res[i].sg ? '0 : res[i].addr;
            end
        end
    end

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
    import pci_dma_xlate_pkg::*;
#(
    parameter int              NWIN       = 4,
    parameter int              RA_W       = 32,
    parameter logic [RA_W-1:0] BASE_ADDR  = 32'h0001_0000,
    parameter int              FIELD_LSB  = 20,
    parameter int              FIELD_BITS = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_req,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [1:0]      reg_size,
    input  logic [63:0]     reg_wdata,
    output logic [63:0]     reg_rdata,
    output logic            reg_err,
    input  logic [63:0]     bus_addr,
    output logic            xl_hit,
    output logic            xl_err,
    output logic [63:0]     xl_addr
);

    win_cfg_t [NWIN-1:0] cfg;
    win_res_t [NWIN-1:0] res;

    pdx_regbank #(
        .NWIN      (NWIN),
        .RA_W      (RA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .cfg       (cfg)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        pdx_window #(
            .FIELD_LSB  (FIELD_LSB),
            .FIELD_BITS (FIELD_BITS)
        ) u_win (
            .cfg      (cfg[w]),
            .bus_addr (bus_addr),
            .res      (res[w])
        );
    end

    pdx_pick #(
        .NWIN (NWIN)
    ) u_pick (
        .res  (res),
        .hit  (xl_hit),
        .err  (xl_err),
        .addr (xl_addr)
    );

endmodule

// File: rtl/pci_dma_xlate_chk.sv
module pci_dma_xlate_chk #(
    parameter int RA_W      = 32,
    parameter int FIELD_LSB = 20
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_req,
    input logic [1:0]      reg_size,
    input logic [63:0]     reg_rdata,
    input logic            reg_err,
    input logic [63:0]     bus_addr,
    input logic            xl_hit,
    input logic            xl_err,
    input logic [63:0]     xl_addr
);

    // R2
    narrow_err_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_size != 2'd3) |-> (reg_err && reg_rdata == '0));

    // R5
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> (xl_addr[FIELD_LSB-1:0] == bus_addr[FIELD_LSB-1:0]));

    // R7
    sg_block_chk: assert property (@(posedge clk) disable iff (rst)
        xl_err |-> (!xl_hit && xl_addr == '0));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!xl_hit && !xl_err) |-> (xl_addr == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!xl_hit && !xl_err));

endmodule

bind pci_dma_xlate pci_dma_xlate_chk #(
    .RA_W      (RA_W),
    .FIELD_LSB (FIELD_LSB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_req   (reg_req),
    .reg_size  (reg_size),
    .reg_rdata (reg_rdata),
    .reg_err   (reg_err),
    .bus_addr  (bus_addr),
    .xl_hit    (xl_hit),
    .xl_err    (xl_err),
    .xl_addr   (xl_addr)
);

// File: tb/tb_pci_dma_xlate.sv
module tb_pci_dma_xlate;

    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [1:0]  reg_size = 2'd3;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic [63:0] bus_addr = '0;
    logic        xl_hit;
    logic        xl_err;
    logic [63:0] xl_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pci_dma_xlate dut (
        .clk       (clk),
        .rst       (rst),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .bus_addr  (bus_addr),
        .xl_hit    (xl_hit),
        .xl_err    (xl_err),
        .xl_addr   (xl_addr)
    );

    function automatic logic [31:0] at(input logic [31:0] idx);
        return BASE + (idx << 6);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [63:0] d,
                      input logic [1:0] sz, output logic e);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        #1 e = reg_err;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0; reg_size = 2'd3;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz,
                      output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_size = sz;
        #1 d = reg_rdata; e = reg_err;
        @(negedge clk);
        reg_req = 1'b0; reg_size = 2'd3;
    endtask

    task automatic xl(input string req, input logic [63:0] a, input logic eh,
                      input logic ee, input logic [63:0] ea);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, "xl_hit", 64'(xl_hit), 64'(eh));
        check(req, "xl_err", 64'(xl_err), 64'(ee));
        check(req, "xl_addr", xl_addr, ea);
    endtask

    task automatic wr_ok(input string req, input logic [31:0] idx, input logic [63:0] d);
        logic e;
        wr(at(idx), d, 2'd3, e);
        check(req, "write err", 64'(e), 64'd0);
    endtask

    task automatic rd_expect(input string req, input logic [31:0] a, input logic [1:0] sz,
                             input logic [63:0] ed, input logic ee);
        logic [63:0] d;
        logic e;
        rd(a, sz, d, e);
        check(req, "rdata", d, ed);
        check(req, "reg_err", 64'(e), 64'(ee));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 12; i++) rd_expect("R11", at(i), 2'd3, 64'd0, 1'b0);
        xl("R11", 64'h0000_0000_4123_4567, 1'b0, 1'b0, 64'd0);
    endtask

    task automatic t_regs;
        wr_ok("R1", 0, 64'h0000_0000_4000_0001);
        wr_ok("R1", 4, 64'h0000_0000_0FF0_0000);
        wr_ok("R1", 8, 64'h0000_0001_2000_0000);
        wr_ok("R1", 3, 64'h0000_0000_0030_0001);
        wr_ok("R1", 7, 64'h0);
        wr_ok("R1", 11, 64'h0000_00AB_CDE0_0000);
        rd_expect("R1", at(0), 2'd3, 64'h0000_0000_4000_0001, 1'b0);
        rd_expect("R1", at(4), 2'd3, 64'h0000_0000_0FF0_0000, 1'b0);
        rd_expect("R1", at(8), 2'd3, 64'h0000_0001_2000_0000, 1'b0);
        rd_expect("R1", at(3), 2'd3, 64'h0000_0000_0030_0001, 1'b0);
        rd_expect("R1", at(11), 2'd3, 64'h0000_00AB_CDE0_0000, 1'b0);
        rd_expect("R1", at(1), 2'd3, 64'h0, 1'b0);
    endtask

    task automatic t_direct;
        xl("R5", 64'h0000_0000_4123_4567, 1'b1, 1'b0, 64'h0000_0001_2123_4567);
        xl("R3", 64'h0000_0000_C123_4567, 1'b1, 1'b0, 64'h0000_0001_2123_4567);
        xl("R3", 64'h0000_0000_0035_1234, 1'b1, 1'b0, 64'h0000_00AB_CDE5_1234);
        xl("R3", 64'h0000_0000_0045_1234, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic t_enable;
        wr_ok("R4", 1, 64'h0000_0000_5000_0000);
        wr_ok("R4", 5, 64'h0000_0000_0FF0_0000);
        wr_ok("R4", 9, 64'h0000_0000_8000_0000);
        xl("R8", 64'h0000_0000_5123_4567, 1'b0, 1'b0, 64'h0);
        wr_ok("R4", 1, 64'h0000_0000_5000_0001);
        xl("R4", 64'h0000_0000_5123_4567, 1'b1, 1'b0, 64'h0000_0000_8123_4567);
    endtask

    task automatic t_priority;
        wr_ok("R6", 2, 64'h0000_0000_4000_0001);
        wr_ok("R6", 6, 64'h0000_0000_7FF0_0000);
        wr_ok("R6", 10, 64'h0000_0002_0000_0000);
        xl("R6", 64'h0000_0000_4123_4567, 1'b1, 1'b0, 64'h0000_0001_2123_4567);
        xl("R6", 64'h0000_0000_6000_0010, 1'b1, 1'b0, 64'h0000_0002_6000_0010);
        xl("R6", 64'h0000_0000_0035_1234, 1'b1, 1'b0, 64'h0000_0002_0035_1234);
    endtask

    task automatic t_sg;
        wr_ok("R7", 1, 64'h0000_0000_5000_0003);
        xl("R7", 64'h0000_0000_5123_4567, 1'b0, 1'b1, 64'h0);
        wr_ok("R7", 1, 64'h0000_0000_5000_0002);
        xl("R7", 64'h0000_0000_5123_4567, 1'b1, 1'b0, 64'h0000_0002_5123_4567);
    endtask

    task automatic t_size;
        logic e;
        wr(at(0), 64'h0, 2'd2, e);
        check("R2", "32-bit write err", 64'(e), 64'd1);
        wr(at(4), 64'h0, 2'd0, e);
        check("R2", "8-bit write err", 64'(e), 64'd1);
        rd_expect("R2", at(0), 2'd3, 64'h0000_0000_4000_0001, 1'b0);
        rd_expect("R2", at(4), 2'd3, 64'h0000_0000_0FF0_0000, 1'b0);
        rd_expect("R2", at(0), 2'd1, 64'h0, 1'b1);
    endtask

    task automatic t_const;
        wr_ok("R9", 12, 64'hFFFF_FFFF_FFFF_FFFF);
        wr_ok("R9", 13, 64'h1234_5678_9ABC_DEF0);
        rd_expect("R9", at(12), 2'd3, 64'h0, 1'b0);
        rd_expect("R9", at(13), 2'd3, 64'h0, 1'b0);
        xl("R9", 64'h0000_0000_4123_4567, 1'b1, 1'b0, 64'h0000_0001_2123_4567);
    endtask

    task automatic t_bad;
        logic e;
        for (int i = 14; i <= 20; i++) rd_expect("R10", at(i), 2'd3, 64'h0, 1'b1);
        rd_expect("R10", at(31), 2'd3, 64'h0, 1'b1);
        rd_expect("R10", at(32), 2'd3, 64'h0, 1'b1);
        rd_expect("R10", BASE - 32'd64, 2'd3, 64'h0, 1'b1);
        wr(at(14), 64'hDEAD_BEEF, 2'd3, e);
        check("R10", "write err", 64'(e), 64'd1);
        wr(at(32), 64'hDEAD_BEEF, 2'd3, e);
        check("R10", "write err wrap", 64'(e), 64'd1);
        rd_expect("R10", at(0), 2'd3, 64'h0000_0000_4000_0001, 1'b0);
        rd_expect("R10", at(8), 2'd3, 64'h0000_0001_2000_0000, 1'b0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_direct();
        t_enable();
        t_priority();
        t_sg();
        t_size();
        t_const();
        t_bad();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule